// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for a pin count that is a multiple of 32. Software reaches it through a plain 32-bit register port made of a word address, a write strobe, write data and a combinational read-data return. Toward the pads it gives each pin an input, an output value and an output enable, plus a 2-bit alternate-function code that other logic can use to steer the pin away from plain GPIO.

Register storage is laid out feature-major. Each feature occupies a run of NUM_PINS/32 consecutive words. Output values change through separate write-one set and clear words, so one pin can be changed without a read-modify-write. Rising and falling transitions on the synchronised inputs can each be enabled per pin. A detected transition is held in a sticky status bit that software clears by writing one. A single interrupt line stays high while any status bit is set.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: With NREG = NUM_PINS/32, the feature groups are numbered level 0, direction 1, set 2, clear 3, rise enable 4, fall enable 5, status 6 and alternate function 7. Word r of group g sits at byte address (g*NREG + r)*4, and address bits [1:0] are ignored. Pin p is bit p%32 of word p/32.
- R2: A level word reads the pad inputs after a two-flop synchroniser, whatever the pin's direction. A change becomes readable two clocks after it arrives, and writes to a level word have no effect.
- R3: A direction word reads back as written. A 1 in bit p drives pad_oe[p] high from the clock edge of the write.
- R4: Writing a set word raises pad_out for every bit written as 1, and writing a clear word lowers them. Bits written as 0 leave their pins unchanged. Set and clear words read as zero.
- R5: When a pin's rise-enable bit is 1 and its synchronised input goes from 0 to 1, its status bit is set on the third clock edge after the pad change. With the enable at 0, no status bit is set.
- R6: When a pin's fall-enable bit is 1, a 1-to-0 change sets its status bit with the same timing. With both enables at 1, either direction sets the status bit.
- R7: Writing 1 to a status bit clears it. Status bits written as 0 keep their value.
- R8: When a clearing write and a new enabled edge on the same pin fall on the same clock edge, the status bit stays set.
- R9: irq is high exactly while at least one status bit in any word is set.
- R10: Alternate-function words hold 2 bits per pin, 16 pins per word, starting at group 7. Pin p uses word p/16, bits [2*(p%16)+1 : 2*(p%16)], and drives pad_alt[2p+1:2p]. The words read back as written, and code 0 means plain GPIO.
- R11: Word indices at or above 7*NREG + 2*NREG read as zero, and writes to them change nothing.
- R12: After reset, direction, output, both enables, status, alternate-function codes and irq are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | NUM_PINS | Asynchronous pad inputs |
| pad_out | output | NUM_PINS | Output latch values |
| pad_oe | output | NUM_PINS | Output enables (1 = output) |
| pad_alt | output | 2*NUM_PINS | Alternate-function code, 2 bits per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
The bench builds the controller with 96 pins, so every feature spans three words. The word decode therefore has to divide by a count that is not a power of two, and the alternate-function block runs to six words, which puts its end at an index far from any power-of-two boundary. Pins in the top word (64 to 95) and in the top alternate-function word (pin 95) are used on purpose to reach the last word of each group. The first unmapped word follows directly after the alternate-function block.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int WORD_W = 32;

   // Order of feature groups in the address map; the decode depends on it.
   typedef enum int {
      GRP_LEVEL = 0,
      GRP_DIR   = 1,
      GRP_SET   = 2,
      GRP_CLR   = 3,
      GRP_REN   = 4,
      GRP_FEN   = 5,
      GRP_STS   = 6,
      GRP_ALT   = 7
   } gpio_grp_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_word.sv
module gpio_edge_word #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] rise_en,
   input  logic [W-1:0] fall_en,
   input  logic         clr_we,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] status
);
   logic [W-1:0] prev_q;
   logic [W-1:0] hit;
   logic [W-1:0] wipe;

   assign hit  = (lvl & ~prev_q & rise_en) | (~lvl & prev_q & fall_en);
   assign wipe = clr_we ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         status <= '0;
      end else begin
         prev_q <= lvl;
         // A fresh edge is ORed in after the clear, so it survives.
         status <= (status & ~wipe) | hit;
      end
   end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS    = 64,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic [WORD_W-1:0]     bus_wdata,
   output logic [WORD_W-1:0]     bus_rdata,
   input  logic [NUM_PINS-1:0]   pad_in,
   output logic [NUM_PINS-1:0]   pad_out,
   output logic [NUM_PINS-1:0]   pad_oe,
   output logic [2*NUM_PINS-1:0] pad_alt,
   output logic                  irq
);
   localparam int NREG   = NUM_PINS / WORD_W;
   localparam int NALT   = 2 * NREG;
   localparam int NWORDS = int'(GRP_ALT) * NREG + NALT;
   localparam int WIDX_W = ADDR_W - 2;

   if (NUM_PINS <= 0 || (NUM_PINS % WORD_W) != 0) begin : g_bad_pins
      $error("NUM_PINS must be a positive multiple of 32");
   end
   if (NWORDS * 4 > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic [WIDX_W-1:0]    widx;
   logic [NUM_PINS-1:0]  lvl;
   logic [NUM_PINS-1:0]  dir_q, out_q, ren_q, fen_q, sts;
   logic [2*NUM_PINS-1:0] alt_q;

   assign widx = bus_addr[ADDR_W-1:2];

   function automatic logic is_word(input logic [WIDX_W-1:0] w,
                                    input gpio_grp_e grp, input int r);
      return int'(w) == int'(grp) * NREG + r;
   endfunction

   gpio_pin_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         out_q <= '0;
         ren_q <= '0;
         fen_q <= '0;
         alt_q <= '0;
      end else if (bus_we) begin
         for (int r = 0; r < NREG; r++) begin
            if (is_word(widx, GRP_DIR, r)) dir_q[r*WORD_W +: WORD_W] <= bus_wdata;
            if (is_word(widx, GRP_SET, r))
               out_q[r*WORD_W +: WORD_W] <= out_q[r*WORD_W +: WORD_W] | bus_wdata;
            if (is_word(widx, GRP_CLR, r))
               out_q[r*WORD_W +: WORD_W] <= out_q[r*WORD_W +: WORD_W] & ~bus_wdata;
            if (is_word(widx, GRP_REN, r)) ren_q[r*WORD_W +: WORD_W] <= bus_wdata;
            if (is_word(widx, GRP_FEN, r)) fen_q[r*WORD_W +: WORD_W] <= bus_wdata;
         end
         for (int a = 0; a < NALT; a++) begin
            if (is_word(widx, GRP_ALT, a)) alt_q[a*WORD_W +: WORD_W] <= bus_wdata;
         end
      end
   end

   for (genvar r = 0; r < NREG; r++) begin : g_edge
      logic clr_we;
      assign clr_we = bus_we && is_word(widx, GRP_STS, r);
      gpio_edge_word #(.W(WORD_W)) u_edge (
         .clk      (clk),
         .rst_n    (rst_n),
         .lvl      (lvl[r*WORD_W +: WORD_W]),
         .rise_en  (ren_q[r*WORD_W +: WORD_W]),
         .fall_en  (fen_q[r*WORD_W +: WORD_W]),
         .clr_we   (clr_we),
         .clr_mask (bus_wdata),
         .status   (sts[r*WORD_W +: WORD_W])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int r = 0; r < NREG; r++) begin
         if (is_word(widx, GRP_LEVEL, r)) bus_rdata = lvl[r*WORD_W +: WORD_W];
         if (is_word(widx, GRP_DIR, r))   bus_rdata = dir_q[r*WORD_W +: WORD_W];
         if (is_word(widx, GRP_REN, r))   bus_rdata = ren_q[r*WORD_W +: WORD_W];
         if (is_word(widx, GRP_FEN, r))   bus_rdata = fen_q[r*WORD_W +: WORD_W];
         if (is_word(widx, GRP_STS, r))   bus_rdata = sts[r*WORD_W +: WORD_W];
      end
      for (int a = 0; a < NALT; a++) begin
         if (is_word(widx, GRP_ALT, a)) bus_rdata = alt_q[a*WORD_W +: WORD_W];
      end
   end

   assign pad_out = out_q;
   assign pad_oe  = dir_q;
   assign pad_alt = alt_q;
   assign irq     = |sts;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
   parameter int NUM_PINS = 64,
   parameter int ADDR_W   = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic                  bus_we,
   input logic [31:0]           bus_wdata,
   input logic [31:0]           bus_rdata,
   input logic [NUM_PINS-1:0]   pad_out,
   input logic [NUM_PINS-1:0]   pad_oe,
   input logic                  irq
);
   localparam int NREG   = NUM_PINS / 32;
   localparam int NWORDS = 9 * NREG;
   localparam int DIR_W0 = 1 * NREG;
   localparam int SET_W0 = 2 * NREG;
   localparam int CLR_W0 = 3 * NREG;

   logic [ADDR_W-3:0] widx;
   assign widx = bus_addr[ADDR_W-1:2];

   // R4: a set write with bit 0 raises pin 0
   p_set_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && int'(widx) == SET_W0 && bus_wdata[0]) |=> pad_out[0]);

   // R4: a clear write with bit 0 lowers pin 0
   p_clr_lowers_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && int'(widx) == CLR_W0 && bus_wdata[0]) |=> !pad_out[0]);

   // R3: enables of word 0 move only on a write to that direction word
   p_oe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && int'(widx) == DIR_W0) |=> $stable(pad_oe[31:0]));

   // R7: without a bus write, a pending interrupt cannot go away
   p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !bus_we) |=> irq);

   // R11: unmapped reads return zero
   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(widx) >= NWORDS) |-> (bus_rdata == 32'h0));

   // R12: quiet outputs right after reset release
   p_reset_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq && pad_oe == '0 && pad_out == '0));
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .irq       (irq)
);

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
   localparam int NP   = 96;
   localparam int AW   = 8;
   localparam int NREG = NP / 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [AW-1:0]  bus_addr = '0;
   logic           bus_we = 1'b0;
   logic [31:0]    bus_wdata = '0;
   logic [31:0]    bus_rdata;
   logic [NP-1:0]  pad_in = '0;
   logic [NP-1:0]  pad_out, pad_oe;
   logic [2*NP-1:0] pad_alt;
   logic           irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #5 clk = ~clk;

   gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_alt(pad_alt), .irq(irq)
   );

   // R1: byte address of word r in group g
   function automatic logic [AW-1:0] wa(input int g, input int r);
      return AW'((g * NREG + r) * 4);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Called in the low clock phase; the write lands on the next rising edge.
   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      bus_addr = a; bus_we = 1'b0;
      #1 d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R12 irq", 32'(irq), 32'h0);
      chk("R12 pad_oe", pad_oe[31:0] | pad_oe[63:32] | pad_oe[95:64], 32'h0);
      chk("R12 pad_out", pad_out[31:0] | pad_out[63:32] | pad_out[95:64], 32'h0);
      chk("R12 pad_alt", 32'(|pad_alt), 32'h0);
      rd(wa(4, 2), v); chk("R12 rise enable", v, 32'h0);
      rd(wa(6, 1), v); chk("R12 status", v, 32'h0);
   endtask

   task automatic t_level();
      logic [31:0] v;
      pad_in = {32'hA5A5_0F0F, 32'h1234_5678, 32'hDEAD_BEEF};
      @(negedge clk);
      rd(wa(0, 0), v); chk("R2 level not yet after one clock", v, 32'h0);
      @(negedge clk);
      rd(wa(0, 0), v); chk("R2 R1 level word0", v, 32'hDEAD_BEEF);
      rd(wa(0, 1), v); chk("R2 R1 level word1", v, 32'h1234_5678);
      rd(wa(0, 2), v); chk("R2 R1 level word2", v, 32'hA5A5_0F0F);
      wr(wa(0, 1), 32'h0);
      rd(wa(0, 1), v); chk("R2 level write ignored", v, 32'h1234_5678);
   endtask

   task automatic t_dir();
      logic [31:0] v;
      wr(wa(1, 1), 32'h0000_FFFF);
      chk("R3 pad_oe word1", pad_oe[63:32], 32'h0000_FFFF);
      chk("R3 pad_oe word0 untouched", pad_oe[31:0], 32'h0);
      rd(wa(1, 1), v); chk("R3 direction readback", v, 32'h0000_FFFF);
      rd(wa(0, 1), v); chk("R2 level independent of direction", v, 32'h1234_5678);
   endtask

   task automatic t_setclr();
      logic [31:0] v;
      wr(wa(2, 2), 32'h8000_0001);
      chk("R4 set word2", pad_out[95:64], 32'h8000_0001);
      wr(wa(2, 2), 32'h0);
      chk("R4 zero set no effect", pad_out[95:64], 32'h8000_0001);
      wr(wa(3, 2), 32'h0000_0001);
      chk("R4 clear one bit", pad_out[95:64], 32'h8000_0000);
      rd(wa(2, 2), v); chk("R4 set reads zero", v, 32'h0);
      rd(wa(3, 2), v); chk("R4 clear reads zero", v, 32'h0);
   endtask

   task automatic t_rise();
      logic [31:0] v;
      pad_in = '0;
      repeat (4) @(negedge clk);
      wr(wa(4, 0), 32'h0000_0020);
      pad_in[5] = 1'b1;
      pad_in[6] = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R5 no status before third edge", 32'(irq), 32'h0);
      @(negedge clk);
      chk("R5 R9 irq after enabled rise", 32'(irq), 32'h1);
      rd(wa(6, 0), v); chk("R5 only enabled pin flagged", v, 32'h0000_0020);
   endtask

   task automatic t_clear();
      logic [31:0] v;
      wr(wa(6, 0), 32'h0);
      rd(wa(6, 0), v); chk("R7 zero write keeps status", v, 32'h0000_0020);
      wr(wa(6, 0), 32'h0000_0020);
      rd(wa(6, 0), v); chk("R7 write one clears", v, 32'h0);
      chk("R9 irq low with no status", 32'(irq), 32'h0);
   endtask

   task automatic t_fall();
      logic [31:0] v;
      pad_in[67] = 1'b1;
      pad_in[68] = 1'b1;
      repeat (4) @(negedge clk);
      wr(wa(5, 2), 32'h0000_0018);
      wr(wa(4, 2), 32'h0000_0010);
      pad_in[67] = 1'b0;
      repeat (3) @(negedge clk);
      rd(wa(6, 2), v); chk("R6 falling edge flagged", v, 32'h0000_0008);
      wr(wa(6, 2), 32'hFFFF_FFFF);
      rd(wa(6, 2), v); chk("R7 all-ones clears word", v, 32'h0);
      pad_in[68] = 1'b0;
      repeat (3) @(negedge clk);
      rd(wa(6, 2), v); chk("R6 both enables, fall", v, 32'h0000_0010);
      wr(wa(6, 2), 32'h0000_0010);
      pad_in[68] = 1'b1;
      repeat (3) @(negedge clk);
      rd(wa(6, 2), v); chk("R6 both enables, rise", v, 32'h0000_0010);
      chk("R9 irq from upper word", 32'(irq), 32'h1);
      wr(wa(6, 2), 32'h0000_0010);
   endtask

   task automatic t_edge_wins();
      logic [31:0] v;
      wr(wa(5, 0), 32'h0000_0020);
      pad_in[5] = 1'b0;
      repeat (3) @(negedge clk);
      rd(wa(6, 0), v); chk("R6 fall on pin 5", v, 32'h0000_0020);
      pad_in[5] = 1'b1;
      @(negedge clk); @(negedge clk);
      wr(wa(6, 0), 32'h0000_0020);
      rd(wa(6, 0), v); chk("R8 new edge beats clear", v, 32'h0000_0020);
      wr(wa(6, 0), 32'h0000_0020);
      rd(wa(6, 0), v); chk("R8 later clear succeeds", v, 32'h0);
   endtask

   task automatic t_alt();
      logic [31:0] v;
      wr(wa(7, 2), 32'h0002_0000);
      chk("R10 pin 40 code", 32'(pad_alt[81:80]), 32'h2);
      wr(wa(7, 5), 32'hC000_0000);
      chk("R10 pin 95 code", 32'(pad_alt[191:190]), 32'h3);
      chk("R10 pin 94 untouched", 32'(pad_alt[189:188]), 32'h0);
      rd(wa(7, 5), v); chk("R10 alt readback", v, 32'hC000_0000);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      logic [NP-1:0] oe0, out0;
      logic [2*NP-1:0] alt0;
      oe0 = pad_oe; out0 = pad_out; alt0 = pad_alt;
      rd(wa(9, 0), v); chk("R11 first unmapped reads zero", v, 32'h0);
      rd(AW'(8'hFC), v); chk("R11 top address reads zero", v, 32'h0);
      wr(wa(9, 0), 32'hFFFF_FFFF);
      wr(AW'(8'hFC), 32'hFFFF_FFFF);
      chk("R11 write leaves pad_oe", 32'(pad_oe != oe0), 32'h0);
      chk("R11 write leaves pad_out", 32'(pad_out != out0), 32'h0);
      chk("R11 write leaves pad_alt", 32'(pad_alt != alt0), 32'h0);
      chk("R11 write leaves irq", 32'(irq), 32'h0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_level();
      t_dir();
      t_setclr();
      t_rise();
      t_clear();
      t_fall();
      t_edge_wins();
      t_alt();
      t_unmapped();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule